// File: doc/BRIEF.md
# Traffic Test Control Register File

This block is a word-addressed register file that sits between a management bus and the traffic generators and checkers of a packet test harness. Software writes to it to start a send burst, to choose continuous generation, and to clear the checkers' error state. It reads back the packet start and end counts and the error figures that the generator and checker blocks report. Those values arrive on a flat vector of status words and are shown as read-only registers.

It also holds a rate-switch request word for a management agent. Software writes a tile-type bit, a three-bit direction code and an enable bit. The agent sees the request on dedicated pins, does the rate change, and then pulses a done input. That pulse clears the enable bit. Software polls the enable bit until it reads back as zero to learn that the switch has finished. While a request is pending, the stored word cannot be changed from the bus.

The bus has no wait states. A write takes effect on the clock edge where `bus_wr` is high. A read issued with `bus_rd` returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle. The block never stalls the bus, so it has no ready signal. Word `i` of `stat_words` (bits `i*DATA_W +: DATA_W`) appears at offset 0x04+i.

Top module: `tcr_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `start_pulse`, `clr_err_pulse`, `cont_en`, `sw_req_valid`, `sw_tile`, `sw_dir`, `bus_rvalid` and `bus_rdata` are all zero.
- R2: A read with `bus_rd` high at an edge gives `bus_rvalid` high for exactly the next cycle, with the data of the addressed word as it stood before any write at that same edge. When `bus_rvalid` is low, `bus_rdata` is zero.
- R3: A write to offset 0x01 with data bit 0 set raises `start_pulse` for the one cycle after that edge. A write with bit 0 clear does nothing. Offset 0x01 reads as zero.
- R4: Offset 0x02 bit 0 is a read/write continuous-mode bit that drives `cont_en`. Its other bits read as zero.
- R5: A write to offset 0x03 with data bit 0 set raises `clr_err_pulse` for one cycle. Offset 0x03 reads as zero.
- R6: Offsets 0x04 to 0x11 read status word 0 to 13 of `stat_words`. A write to them has no effect.
- R7: Offset 0x00 and every offset from 0x13 upward read as zero. A write to them has no effect on any output or register.
- R8: Offset 0x12 holds the tile type in bit 7, the direction code in bits 6:4 (000 = high-to-low rate, 001 = low-to-high rate) and the enable in bit 0. Its other bits read zero. When the enable is clear, a write loads all three fields.
- R9: While the enable bit of offset 0x12 is set, every bus write to offset 0x12 is ignored, including a write of zero to bit 0. The tile and direction fields hold their values.
- R10: A `sw_done` pulse while the enable is set clears the enable at that edge. If a write to 0x12 arrives at the same edge, the write is ignored. A `sw_done` pulse while the enable is clear has no effect.
- R11: `sw_req_valid` equals the stored enable bit. `sw_tile` and `sw_dir` show the stored tile and direction fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid, else zero |
| bus_rvalid | output | 1 | Read response, one cycle after bus_rd |
| stat_words | input | 14*DATA_W | Status words from the generators and checkers |
| start_pulse | output | 1 | One-cycle send-start strobe |
| cont_en | output | 1 | Continuous generation enable |
| clr_err_pulse | output | 1 | One-cycle error-clear strobe |
| sw_req_valid | output | 1 | Rate-switch request pending |
| sw_tile | output | 1 | Requested tile type |
| sw_dir | output | 3 | Requested switch direction code |
| sw_done | input | 1 | Agent completion pulse |

## Verification
The assertions assume three things about the inputs. The strobes are low during reset. `sw_done` comes only as a one-cycle pulse. At most one access happens per cycle per strobe. Nothing is assumed about how reads and writes overlap, so the stimulus drives every input only just after a rising edge. It mixes directed sequences with pseudo-random ones in which reads and writes land at the same edge, `sw_done` arrives while idle and together with writes to 0x12, and the status words change between reads. A behavioural model in the bench follows every edge and checks all outputs on every cycle.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int OFF_START     = 1;
  localparam int OFF_CONT      = 2;
  localparam int OFF_CLR       = 3;
  localparam int OFF_STAT_LO   = 4;
  localparam int NSTAT         = 14;
  localparam int OFF_STAT_HI   = OFF_STAT_LO + NSTAT - 1;
  localparam int OFF_RATE      = OFF_STAT_HI + 1;
  localparam int STAT_IDX_W    = $clog2(NSTAT);
  localparam int RATE_EN_BIT   = 0;
  localparam int RATE_DIR_LO   = 4;
  localparam int RATE_DIR_W    = 3;
  localparam int RATE_TILE_BIT = 7;
  localparam int NPULSE        = 2;

  typedef struct packed {
    logic                  hit_start;
    logic                  hit_cont;
    logic                  hit_clr;
    logic                  hit_stat;
    logic                  hit_rate;
    logic                  hit_none;
    logic [STAT_IDX_W-1:0] stat_idx;
  } sel_t;

  typedef struct packed {
    logic                  tile;
    logic [RATE_DIR_W-1:0] dir;
    logic                  en;
  } rate_t;
endpackage

// File: rtl/tcr_decode.sv
module tcr_decode
  import tcr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  logic [ADDR_W-1:0] stat_off;

  always_comb begin
    stat_off       = addr - ADDR_W'(OFF_STAT_LO);
    sel.hit_start  = (addr == ADDR_W'(OFF_START));
    sel.hit_cont   = (addr == ADDR_W'(OFF_CONT));
    sel.hit_clr    = (addr == ADDR_W'(OFF_CLR));
    sel.hit_stat   = (addr >= ADDR_W'(OFF_STAT_LO)) && (addr <= ADDR_W'(OFF_STAT_HI));
    sel.hit_rate   = (addr == ADDR_W'(OFF_RATE));
    sel.hit_none   = !(sel.hit_start || sel.hit_cont || sel.hit_clr ||
                       sel.hit_stat || sel.hit_rate);
    sel.stat_idx   = sel.hit_stat ? stat_off[STAT_IDX_W-1:0] : '0;
  end
endmodule

// File: rtl/tcr_ctrl_bits.sv
module tcr_ctrl_bits
  import tcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit0,
  input  sel_t sel,
  output logic start_pulse,
  output logic clr_pulse,
  output logic cont_en
);
  logic [NPULSE-1:0] pulse_hit;
  logic [NPULSE-1:0] pulse_q;

  assign pulse_hit = {sel.hit_clr, sel.hit_start};

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[g] <= 1'b0;
      else        pulse_q[g] <= wr && pulse_hit[g] && wbit0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cont_en <= 1'b0;
    else if (wr && sel.hit_cont)  cont_en <= wbit0;
  end

  assign start_pulse = pulse_q[0];
  assign clr_pulse   = pulse_q[1];

  // R3 R5: a strobe can only follow an edge that carried a write
  assert_strobe_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr) |-> !start_pulse && !clr_pulse);
  // R3 R5: the two strobes come from different offsets and never coincide
  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && clr_pulse));
  // R4: continuous bit moves only on a write to its own offset
  assert_cont_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr && sel.hit_cont) |-> $stable(cont_en));
endmodule

// File: rtl/tcr_rate_sw.sv
module tcr_rate_sw
  import tcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  sel_t              sel,
  input  logic              done,
  output rate_t             rate
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate <= '0;
    end else if (rate.en) begin
      if (done) rate.en <= 1'b0;
    end else if (wr && sel.hit_rate) begin
      rate.tile <= wdata[RATE_TILE_BIT];
      rate.dir  <= wdata[RATE_DIR_LO +: RATE_DIR_W];
      rate.en   <= wdata[RATE_EN_BIT];
    end
  end

  // R9: a pending request holds until the agent reports completion
  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rate.en && !done |=> rate.en && $stable(rate.tile) && $stable(rate.dir));
  // R10: completion clears the enable at the next edge
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rate.en && done |=> !rate.en);
  // R8: a request appears only through a bus write to the rate word
  assert_set_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate.en) |-> $past(wr && sel.hit_rate));
  // R10: the enable only falls on a done pulse
  assert_fall_by_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rate.en) |-> $past(done));
endmodule

// File: rtl/tcr_rd_mux.sv
module tcr_rd_mux
  import tcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd,
  input  sel_t                    sel,
  input  logic [NSTAT*DATA_W-1:0] stat_words,
  input  logic                    cont_en,
  input  rate_t                   rate,
  output logic [DATA_W-1:0]       rdata,
  output logic                    rvalid
);
  logic [DATA_W-1:0] stat_arr [NSTAT];
  logic [DATA_W-1:0] rate_word;
  logic [DATA_W-1:0] rd_next;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    assign stat_arr[g] = stat_words[g*DATA_W +: DATA_W];
  end

  always_comb begin
    rate_word                             = '0;
    rate_word[RATE_TILE_BIT]              = rate.tile;
    rate_word[RATE_DIR_LO +: RATE_DIR_W]  = rate.dir;
    rate_word[RATE_EN_BIT]                = rate.en;
    rd_next = '0;
    if (sel.hit_cont)      rd_next = DATA_W'(cont_en);
    else if (sel.hit_stat) rd_next = stat_arr[sel.stat_idx];
    else if (sel.hit_rate) rd_next = rate_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? rd_next : '0;
    end
  end

  // R2: a response only ever follows a read strobe
  assert_rvalid_after_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd));
  // R2: data is quiet outside a response
  assert_rdata_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
  // R7: unmapped offsets answer zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && $past(sel.hit_none) |-> rdata == '0);
  // R3 R5: strobe offsets answer zero
  assert_pulse_regs_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && $past(sel.hit_start || sel.hit_clr) |-> rdata == '0);
endmodule

// File: rtl/tcr_top.sv
module tcr_top
  import tcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_rd,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_rvalid,
  input  logic [NSTAT*DATA_W-1:0] stat_words,
  output logic                    start_pulse,
  output logic                    cont_en,
  output logic                    clr_err_pulse,
  output logic                    sw_req_valid,
  output logic                    sw_tile,
  output logic [RATE_DIR_W-1:0]   sw_dir,
  input  logic                    sw_done
);
  sel_t  sel;
  rate_t rate;

  tcr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  tcr_ctrl_bits u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_wr),
    .wbit0       (bus_wdata[0]),
    .sel         (sel),
    .start_pulse (start_pulse),
    .clr_pulse   (clr_err_pulse),
    .cont_en     (cont_en)
  );

  tcr_rate_sw #(.DATA_W(DATA_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .sel   (sel),
    .done  (sw_done),
    .rate  (rate)
  );

  tcr_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (bus_rd),
    .sel        (sel),
    .stat_words (stat_words),
    .cont_en    (cont_en),
    .rate       (rate),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );

  assign sw_req_valid = rate.en;
  assign sw_tile      = rate.tile;
  assign sw_dir       = rate.dir;

  // R11: direction code seen by the agent stays put for a whole request
  assert_dir_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_valid && $past(sw_req_valid) |-> $stable(sw_dir) && $stable(sw_tile));
endmodule

// File: tb/tcr_top_bench.sv
`timescale 1ns/1ps
module tcr_top_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NS = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [DW-1:0]   bus_wdata = '0;
  logic            bus_rd = 1'b0;
  logic [DW-1:0]   bus_rdata;
  logic            bus_rvalid;
  logic [NS*DW-1:0] stat_words = '0;
  logic            start_pulse, cont_en, clr_err_pulse;
  logic            sw_req_valid, sw_tile;
  logic [2:0]      sw_dir;
  logic            sw_done = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;

  // behavioural model state
  bit        m_start, m_clr, m_cont, m_en, m_tile, m_rv;
  bit [2:0]  m_dir;
  bit [31:0] m_rdata;
  string     m_rtag = "R2";
  bit        m_in_reset = 1;

  always #2.5 clk = ~clk;

  tcr_top #(.ADDR_W(AW), .DATA_W(DW)) u_tcr_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .stat_words(stat_words), .start_pulse(start_pulse),
    .cont_en(cont_en), .clr_err_pulse(clr_err_pulse), .sw_req_valid(sw_req_valid),
    .sw_tile(sw_tile), .sw_dir(sw_dir), .sw_done(sw_done)
  );

  function automatic bit [31:0] model_read(input int a);
    bit [31:0] v = 0;
    if (a == 2) v = {31'd0, m_cont};
    else if (a >= 4 && a <= 17) v = stat_words[(a-4)*DW +: DW];
    else if (a == 18) v = {24'd0, m_tile, m_dir, 3'd0, m_en};
    return v;
  endfunction

  function automatic string read_tag(input int a);
    if (a == 1 || a == 3) return "R3/R5";
    if (a == 2) return "R4";
    if (a >= 4 && a <= 17) return "R6";
    if (a == 18) return "R8/R9";
    return "R7";
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      {m_start, m_clr, m_cont, m_en, m_tile, m_rv} = '0;
      m_dir = 0; m_rdata = 0; m_in_reset = 1;
    end else begin
      m_in_reset = 0;
      m_rv    = bus_rd;
      m_rdata = bus_rd ? model_read(int'(bus_addr)) : 32'd0;
      m_rtag  = bus_rd ? read_tag(int'(bus_addr)) : "R2";
      m_start = bus_wr && bus_addr == 8'h01 && bus_wdata[0];
      m_clr   = bus_wr && bus_addr == 8'h03 && bus_wdata[0];
      if (bus_wr && bus_addr == 8'h02) m_cont = bus_wdata[0];
      if (m_en) begin
        if (sw_done) m_en = 0;
      end else if (bus_wr && bus_addr == 8'h12) begin
        m_tile = bus_wdata[7];
        m_dir  = bus_wdata[6:4];
        m_en   = bus_wdata[0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      chk(m_in_reset ? "R1" : "R3", {31'd0, start_pulse}, {31'd0, m_start});
      chk(m_in_reset ? "R1" : "R5", {31'd0, clr_err_pulse}, {31'd0, m_clr});
      chk(m_in_reset ? "R1" : "R4", {31'd0, cont_en}, {31'd0, m_cont});
      chk(m_in_reset ? "R1" : "R9/R10/R11", {31'd0, sw_req_valid}, {31'd0, m_en});
      chk(m_in_reset ? "R1" : "R8/R11", {28'd0, sw_tile, sw_dir}, {28'd0, m_tile, m_dir});
      chk(m_in_reset ? "R1" : "R2", {31'd0, bus_rvalid}, {31'd0, m_rv});
      chk(m_in_reset ? "R1" : m_rtag, bus_rdata, m_rdata);
    end
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic op(input bit w, input bit r, input int a, input logic [31:0] d, input bit dn);
    @(posedge clk); #1;
    bus_wr = w; bus_rd = r; bus_addr = AW'(a); bus_wdata = d; sw_done = dn;
  endtask

  task automatic wr(input int a, input logic [31:0] d); op(1, 0, a, d, 0); endtask
  task automatic rd(input int a); op(0, 1, a, 0, 0); endtask
  task automatic idle(); op(0, 0, 0, 0, 0); endtask

  task automatic set_stats(input logic [31:0] base);
    for (int i = 0; i < NS; i++) stat_words[i*DW +: DW] = base + 32'(i * 32'h111);
  endtask

  initial begin
    logic [31:0] lf;
    set_stats(32'h1000_0000);
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R6 R7: sweep every offset including unmapped ones
    for (int a = 0; a < 22; a++) rd(a);
    rd(255);
    // R3 R5 R4: strobes and continuous bit
    wr(1, 1); wr(1, 0); idle(); wr(3, 32'hFFFF_FFFF); wr(3, 0);
    wr(2, 32'hFFFF_FFFF); rd(2); rd(1); rd(3);
    wr(2, 32'hFFFF_FFFE); rd(2); wr(2, 1);
    // R6 R7: writes to read-only and unmapped offsets
    wr(5, 32'hDEAD_BEEF); wr(0, 32'hFFFF_FFFF); wr(8'h20, 1); wr(8'h13, 1);
    rd(5); rd(0); rd(8'h13); rd(2); rd(18);
    set_stats(32'hA5A5_0000); rd(4); rd(17);
    // R8 R9 R10 R11: rate-switch handshake
    wr(18, 32'h0000_0091); rd(18);
    wr(18, 32'h0000_0000); rd(18); wr(18, 32'hFFFF_FFFF); rd(18);
    idle(); idle();
    op(0, 0, 0, 0, 1); rd(18);
    op(0, 0, 0, 0, 1); rd(18);
    wr(18, 32'h0000_0001); rd(18);
    op(1, 0, 18, 32'h0000_00F1, 1); rd(18);
    wr(18, 32'hFFFF_FFFF); rd(18); op(0, 1, 18, 0, 1); rd(18);
    wr(18, 32'h0000_0090); rd(18);
    // read and write at the same edge
    op(1, 1, 2, 0, 0); op(1, 1, 18, 32'h11, 0); rd(18);
    // pseudo-random traffic
    lf = 32'h1234_5678;
    for (int k = 0; k < 600; k++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      if (lf[31:29] == 3'd0) set_stats(lf);
      op(lf[7], lf[8], (lf[9] ? 18 : int'(lf[20:16]) % 22), lf ^ {lf[15:0], lf[31:16]},
         lf[12:10] == 3'd0);
    end
    idle(); idle(); idle();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule